// File: doc/BRIEF.md
# Evicted-Address Reuse Filter

This block predicts whether a block that just missed in a cache is worth keeping. It remembers the addresses of recently evicted blocks in a compact bit vector. Each eviction marks two hashed positions. Each miss looks up those same two positions. An address that was evicted only a short time ago and is now wanted again is predicted to have high reuse, and the cache places it at the most-recently-used position. Any other miss is predicted to have low reuse, and the cache places it with its bimodal insertion policy.

Entries cannot be removed one by one. A lookup that matches leaves the entry in the vector. Instead, the block counts how many insertions it has taken since the last wipe. Once that count reaches a limit, set by default to the number of blocks in the cache, the whole vector is wiped and a new epoch starts. Because of this, stale entries age out and a working set larger than the cache cannot keep every member at high priority. When the optional parameter `DUAL_CLEAR` is set, a second counter tracks high-reuse predictions, and reaching the same limit on that counter also starts a wipe.

A small state machine controls the epochs. It has three states:
- `EP_EMPTY`: no insertion since reset or since the last wipe.
- `EP_TRACK`: at least one insertion has been recorded and no limit has been reached.
- `EP_WIPE`: a counter reached the limit in the previous cycle, and everything is cleared at the end of this cycle.

Its transitions are:
- `EP_EMPTY` goes to `EP_TRACK` on an insertion that leaves the count below the limit.
- `EP_EMPTY` or `EP_TRACK` goes to `EP_WIPE` when the count about to be stored equals the limit.
- `EP_TRACK` stays in `EP_TRACK` otherwise.
- `EP_WIPE` goes to `EP_EMPTY` when there is no insertion in the wipe cycle.
- `EP_WIPE` goes to `EP_TRACK` when an insertion in the wipe cycle starts the new epoch.
- `EP_WIPE` goes back to `EP_WIPE` when that single insertion already reaches the limit.

Top module: `evict_reuse_filter`

## Requirements
- R1: After reset, every bit of the vector is zero, both counters are zero and `pred_valid` is low. A lookup made right after reset predicts low reuse.
- R2: An insertion (`ins_valid` high) sets two vector bits. Index A is the XOR of the IDX_W-bit chunks of the address, lowest chunk first, with the address zero-padded to a whole number of chunks. Index B is the same fold applied to the address rotated right by IDX_W/2 bits. With 32-bit addresses and 8-bit indices, A = a[7:0]^a[15:8]^a[23:16]^a[31:24], and B is that fold of {a[3:0],a[31:4]}.
- R3: One cycle after a cycle with `tst_valid` high, `pred_valid` is high and `pred_reuse` is 1 exactly when both hashed bits of `tst_addr` were set. `pred_reuse` is 1 for high reuse and 0 for low reuse. After a cycle with `tst_valid` low, both outputs are low.
- R4: A lookup that matches does not remove the address, so later lookups still match. Lookups never advance the insertion count.
- R5: Each insertion adds one to the insertion count. The insertion that brings the count to BLOCK_LIMIT is recorded. The following cycle is a wipe cycle, and at the end of it the vector and both counters are cleared.
- R6: A lookup sees the vector as it stood at the start of its cycle. It does not see an insertion made in the same cycle, and a lookup made in a wipe cycle still sees the old contents.
- R7: An insertion made during a wipe cycle is kept as the first entry of the new epoch, with the count set to one.
- R8: When DUAL_CLEAR is 1, lookups that predict high reuse outside a wipe cycle are counted. Reaching BLOCK_LIMIT on that count starts a wipe cycle. When DUAL_CLEAR is 0, lookups never cause a wipe.
- R9: Cycles with both `ins_valid` and `tst_valid` low leave the vector and counters unchanged. The block has no input for cache hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | An eviction address is presented for insertion |
| ins_addr | input | ADDR_W | Block address of the evicted line |
| tst_valid | input | 1 | A miss address is presented for lookup |
| tst_addr | input | ADDR_W | Block address of the missed line |
| pred_valid | output | 1 | A prediction for the previous cycle's lookup is present |
| pred_reuse | output | 1 | 1 = high reuse (insert at MRU), 0 = low reuse (bimodal insertion) |

## Verification
The hardest situations to reach from the ports all involve the wipe cycle. In that cycle a lookup must still see the old contents, an insertion must survive into the new epoch, and, in dual mode, the wipe must be caused by matching lookups alone. The stimulus reaches these cases by driving exactly BLOCK_LIMIT insertions, then placing a lookup and an insertion in the very next cycle. For the dual-mode case it inserts a single address and looks it up repeatedly. The bench drives a single-mode and a dual-mode instance side by side with the same stimulus, so the point where their results diverge confirms that matching lookups count only in dual mode.

// File: rtl/erf_pkg.sv
package erf_pkg;

    typedef enum logic [1:0] {
        EP_EMPTY = 2'd0,
        EP_TRACK = 2'd1,
        EP_WIPE  = 2'd2
    } epoch_state_e;

endpackage

// File: rtl/erf_hash.sv
module erf_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx_a,
    output logic [IDX_W-1:0]  idx_b
);
    localparam int NCH  = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PADW = NCH * IDX_W;
    localparam int ROT  = IDX_W / 2;

    logic [ADDR_W-1:0] rot_addr;
    logic [PADW-1:0]   pad_a;
    logic [PADW-1:0]   pad_b;

    // rotate right by half an index width so the second fold mixes other bit pairs
    assign rot_addr = {addr[ROT-1:0], addr[ADDR_W-1:ROT]};
    assign pad_a    = PADW'(addr);
    assign pad_b    = PADW'(rot_addr);

    logic [NCH:0][IDX_W-1:0] acc_a;
    logic [NCH:0][IDX_W-1:0] acc_b;

    assign acc_a[0] = '0;
    assign acc_b[0] = '0;

    for (genvar k = 0; k < NCH; k++) begin : g_fold
        assign acc_a[k+1] = acc_a[k] ^ pad_a[k*IDX_W +: IDX_W];
        assign acc_b[k+1] = acc_b[k] ^ pad_b[k*IDX_W +: IDX_W];
    end

    assign idx_a = acc_a[NCH];
    assign idx_b = acc_b[NCH];

endmodule

// File: rtl/erf_bitvec.sv
module erf_bitvec #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_a,
    input  logic [IDX_W-1:0] set_b,
    input  logic [IDX_W-1:0] rd_a,
    input  logic [IDX_W-1:0] rd_b,
    output logic             hit
);
    localparam int NBITS = 1 << IDX_W;

    logic [NBITS-1:0] bits_q;
    logic [NBITS-1:0] bits_d;

    // per-bit next value: a wipe drops old contents, a set in the same cycle survives
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        assign bits_d[i] = (bits_q[i] & ~wipe)
                         | (set_en & ((set_a == IDX_W'(i)) | (set_b == IDX_W'(i))));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    // lookup reads the registered vector: state at the start of the cycle
    assign hit = bits_q[rd_a] & bits_q[rd_b];

    a_r2_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (bits_q[$past(set_a)] && bits_q[$past(set_b)]));

    a_r5_wipe_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe && !set_en) |=> (bits_q == '0));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && !set_en) |=> $stable(bits_q));

endmodule

// File: rtl/erf_epoch_ctrl.sv
module erf_epoch_ctrl
    import erf_pkg::*;
#(
    parameter int BLOCK_LIMIT = 1024,
    parameter bit DUAL_CLEAR  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ins_valid,
    input  logic hit_event,
    output logic wipe
);
    localparam int CNT_W = $clog2(BLOCK_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(BLOCK_LIMIT);

    epoch_state_e state_q, state_d;
    logic [CNT_W-1:0] ins_cnt_q, ins_cnt_d;
    logic [CNT_W-1:0] hi_cnt_q, hi_cnt_d;
    logic             limit_hit;

    // counter next values
    always_comb begin
        if (state_q == EP_WIPE) begin
            ins_cnt_d = ins_valid ? CNT_W'(1) : '0;
            hi_cnt_d  = '0;
        end else begin
            ins_cnt_d = ins_cnt_q + CNT_W'(ins_valid);
            hi_cnt_d  = hi_cnt_q + CNT_W'(hit_event);
        end
        limit_hit = (ins_cnt_d == LIM) || (DUAL_CLEAR && (hi_cnt_d == LIM));
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EP_EMPTY: begin
                if (limit_hit)      state_d = EP_WIPE;
                else if (ins_valid) state_d = EP_TRACK;
            end
            EP_TRACK: begin
                if (limit_hit)      state_d = EP_WIPE;
            end
            EP_WIPE: begin
                if (limit_hit)      state_d = EP_WIPE;
                else if (ins_valid) state_d = EP_TRACK;
                else                state_d = EP_EMPTY;
            end
            default:                state_d = EP_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_cnt_q <= '0;
            hi_cnt_q  <= '0;
        end else begin
            ins_cnt_q <= ins_cnt_d;
            hi_cnt_q  <= hi_cnt_d;
        end
    end

    // outputs
    always_comb begin
        wipe = (state_q == EP_WIPE);
    end

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ins_cnt_q <= LIM);

    a_r5_limit_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_cnt_q == LIM) |-> (state_q == EP_WIPE));

    a_r7_wipe_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == EP_WIPE) && ins_valid) |=> (ins_cnt_q == CNT_W'(1)));

    a_r4_test_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && (state_q != EP_WIPE)) |=> $stable(ins_cnt_q));

    a_r1_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EP_EMPTY) |-> (ins_cnt_q == '0));

endmodule

// File: rtl/evict_reuse_filter.sv
module evict_reuse_filter #(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 8,
    parameter int BLOCK_LIMIT = 1024,
    parameter bit DUAL_CLEAR  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              tst_valid,
    input  logic [ADDR_W-1:0] tst_addr,
    output logic              pred_valid,
    output logic              pred_reuse
);
    logic [IDX_W-1:0] ins_a, ins_b, tst_a, tst_b;
    logic             hit, wipe;

    erf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_ins (
        .addr  (ins_addr),
        .idx_a (ins_a),
        .idx_b (ins_b)
    );

    erf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_tst (
        .addr  (tst_addr),
        .idx_a (tst_a),
        .idx_b (tst_b)
    );

    erf_bitvec #(.IDX_W(IDX_W)) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe   (wipe),
        .set_en (ins_valid),
        .set_a  (ins_a),
        .set_b  (ins_b),
        .rd_a   (tst_a),
        .rd_b   (tst_b),
        .hit    (hit)
    );

    erf_epoch_ctrl #(.BLOCK_LIMIT(BLOCK_LIMIT), .DUAL_CLEAR(DUAL_CLEAR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .hit_event (tst_valid & hit),
        .wipe      (wipe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_reuse <= 1'b0;
        end else begin
            pred_valid <= tst_valid;
            pred_reuse <= tst_valid & hit;
        end
    end

    a_r3_pred_follows: assert property (@(posedge clk) disable iff (!rst_n)
        tst_valid |=> pred_valid);

    a_r3_pred_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_valid |=> (!pred_valid && !pred_reuse));

    a_r3_reuse_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pred_reuse |-> pred_valid);

endmodule

// File: tb/evict_reuse_filter_tb_top.sv
`timescale 1ns/1ps
module evict_reuse_filter_tb_top;
    localparam int AW  = 32;
    localparam int IW  = 8;
    localparam int LIM = 6;
    localparam int NV  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [AW-1:0] ins_addr = '0;
    logic          tst_valid = 1'b0;
    logic [AW-1:0] tst_addr = '0;
    logic          pv0, pr0, pv1, pr1;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evict_reuse_filter #(.ADDR_W(AW), .IDX_W(IW), .BLOCK_LIMIT(LIM), .DUAL_CLEAR(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
        .tst_valid(tst_valid), .tst_addr(tst_addr), .pred_valid(pv0), .pred_reuse(pr0));

    evict_reuse_filter #(.ADDR_W(AW), .IDX_W(IW), .BLOCK_LIMIT(LIM), .DUAL_CLEAR(1'b1)) dut_dual_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
        .tst_valid(tst_valid), .tst_addr(tst_addr), .pred_valid(pv1), .pred_reuse(pr1));

    // reference state per instance (0 = single clear, 1 = dual clear)
    logic [255:0] mbits [2];
    int           mcnt  [2];
    int           mhi   [2];
    bit           mpend [2];

    // {ins_valid, ins_addr, tst_valid, tst_addr}
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 32'h0,         1'b1, 32'h0000_0100},
        {1'b1, 32'h0000_0100, 1'b0, 32'h0},
        {1'b0, 32'h0,         1'b1, 32'h0000_0100},
        {1'b1, 32'h0000_0200, 1'b1, 32'h0000_0200},
        {1'b0, 32'h0,         1'b1, 32'h0000_0200},
        {1'b0, 32'h0,         1'b1, 32'h1234_5678},
        {1'b1, 32'hA5A5_0001, 1'b0, 32'h0},
        {1'b1, 32'h0BAD_F00D, 1'b1, 32'hA5A5_0001},
        {1'b0, 32'h0,         1'b1, 32'hA5A5_0001},
        {1'b0, 32'h0,         1'b1, 32'h0BAD_F00D},
        {1'b0, 32'h0,         1'b1, 32'h0000_0100},
        {1'b0, 32'h0,         1'b1, 32'h0000_0300}
    };

    function automatic logic [IW-1:0] fold(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24];
    endfunction

    function automatic logic [IW-1:0] hix_a(input logic [AW-1:0] a);
        return fold(a);
    endfunction

    function automatic logic [IW-1:0] hix_b(input logic [AW-1:0] a);
        return fold({a[3:0], a[31:4]});
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            mbits[m] = '0; mcnt[m] = 0; mhi[m] = 0; mpend[m] = 0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ins_valid = 1'b0; tst_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pred_valid in reset single", pv0, 1'b0);
        chk("R1 pred_valid in reset dual", pv1, 1'b0);
        rst_n = 1'b1;
        model_reset();
    endtask

    // one cycle: inputs set at a falling edge, results checked at the next one
    task automatic step(input string tag, input bit iv, input logic [AW-1:0] ia,
                        input bit tv, input logic [AW-1:0] ta);
        logic exp [2];
        ins_valid = iv; ins_addr = ia; tst_valid = tv; tst_addr = ta;
        for (int m = 0; m < 2; m++) begin
            bit present, was;
            present = mbits[m][hix_a(ta)] && mbits[m][hix_b(ta)];
            exp[m] = tv && present;
            was = mpend[m];
            if (was) begin mbits[m] = '0; mcnt[m] = 0; mhi[m] = 0; end
            if (iv) begin
                mbits[m][hix_a(ia)] = 1'b1;
                mbits[m][hix_b(ia)] = 1'b1;
                mcnt[m]++;
            end
            if (!was && tv && present) mhi[m]++;
            mpend[m] = (mcnt[m] == LIM) || ((m == 1) && (mhi[m] == LIM));
        end
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0; tst_valid = 1'b0;
        chk({tag, " valid single"}, pv0, logic'(tv));
        chk({tag, " reuse single"}, pr0, exp[0]);
        chk({tag, " valid dual"}, pv1, logic'(tv));
        chk({tag, " reuse dual"}, pr1, exp[1]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // table walk: R2 hashing, R3 prediction, R6 same-cycle ordering
        for (int v = 0; v < NV; v++) begin
            step("R2 R3 R6 table", VEC[v][65], VEC[v][64:33], VEC[v][32], VEC[v][31:0]);
        end

        // R1: reset empties the vector
        do_reset();
        step("R1 lookup after reset", 1'b0, '0, 1'b1, 32'h0000_0100);
        chk("R1 after reset no reuse", pr0, 1'b0);

        // R4 and R9: hits keep the entry, idle cycles change nothing
        step("R9 insert", 1'b1, 32'h0000_0011, 1'b0, '0);
        for (int i = 0; i < 10; i++) step("R9 idle", 1'b0, '0, 1'b0, '0);
        for (int i = 0; i < 3; i++) begin
            step("R4 repeated hit", 1'b0, '0, 1'b1, 32'h0000_0011);
            chk("R4 entry kept", pr0, 1'b1);
        end

        // R5 and R6: limit reached, lookup in wipe cycle sees old, then empty
        do_reset();
        for (int i = 0; i < LIM; i++) step("R5 fill", 1'b1, 32'h0001_0000 + i * 32'h101, 1'b0, '0);
        step("R6 lookup in wipe cycle", 1'b0, '0, 1'b1, 32'h0001_0000);
        chk("R6 old contents visible", pr0, 1'b1);
        step("R5 lookup after wipe", 1'b0, '0, 1'b1, 32'h0001_0000);
        chk("R5 wiped", pr0, 1'b0);

        // R7: insertion during wipe cycle starts the new epoch
        do_reset();
        for (int i = 0; i < LIM; i++) step("R7 fill", 1'b1, 32'h0002_0000 + i * 32'h202, 1'b0, '0);
        step("R7 insert in wipe", 1'b1, 32'h0000_0077, 1'b0, '0);
        step("R7 survivor", 1'b0, '0, 1'b1, 32'h0000_0077);
        chk("R7 survivor present", pr0, 1'b1);
        step("R7 old gone", 1'b0, '0, 1'b1, 32'h0002_0000);
        for (int i = 0; i < LIM - 1; i++) step("R7 new epoch fill", 1'b1, 32'h0003_0000 + i * 32'h303, 1'b0, '0);
        step("R7 wipe after limit-1", 1'b0, '0, 1'b0, '0);
        step("R7 survivor wiped", 1'b0, '0, 1'b1, 32'h0000_0077);
        chk("R7 count started at one", pr0, 1'b0);

        // R8: repeated hits wipe only the dual instance
        do_reset();
        step("R8 insert", 1'b1, 32'h0000_0055, 1'b0, '0);
        for (int i = 0; i < LIM; i++) step("R8 hit", 1'b0, '0, 1'b1, 32'h0000_0055);
        step("R8 wipe cycle lookup", 1'b0, '0, 1'b1, 32'h0000_0055);
        step("R8 after", 1'b0, '0, 1'b1, 32'h0000_0055);
        chk("R8 single keeps", pr0, 1'b1);
        chk("R8 dual wiped", pr1, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule